// File: doc/BRIEF.md
# TDM Tone Slot Distributor

This block places stored tone samples onto the time slots of a TDM bus. It keeps the current 8-bit PCM sample of each of 24 tones and a 256-entry slot map. Each slot map entry says whether a tone goes out in that bus slot and, if so, which one. On every slot tick the block presents one byte and an output-enable for the slot that has just begun.

An upstream tone source writes new samples once per frame into a shadow copy. The copy becomes live at the frame strobe, so every slot in a frame is drawn from the same set of samples. A host fills the slot map through its own write port, independently of the read side.

A free-running fetch counter reads the map. The counter runs two slots ahead of the bus, which covers the map lookup and the tone lookup. The frame strobe reloads the counter to that lead, so the counter stays locked to the bus frame.

Top module: `tone_slot_dist`

## Requirements
- R1: While reset is held and straight after it, `slot_num` is 0, `slot_oe` is 0 and `slot_data` is the idle code 0xFF.
- R2: Each `slot_tick` without `frame_strobe` advances `slot_num` by one modulo 256, wrapping from 255 to 0 even if no strobe arrives. Between ticks, `slot_num`, `slot_oe` and `slot_data` hold their values.
- R3: After the tick that makes `slot_num` equal k, `slot_oe` is 1 and `slot_data` is the live sample of tone t if map entry k has its valid flag set and t is in 0..23. If the valid flag is clear, `slot_oe` is 0 and `slot_data` is 0xFF.
- R4: A map entry whose flag is set but whose 5-bit tone index is 24..31 behaves as an empty entry: `slot_oe` is 0 and `slot_data` is 0xFF.
- R5: Map entry k is fetched on the tick that starts slot k-1. A host write to entry k that lands earlier in the frame is used in the same frame. A host write in the very clock of that fetch is first seen in the following frame.
- R6: A tone sample written during a frame goes out only from the next frame strobe onward. Before the first strobe after reset, every live sample is 0x00.
- R7: A tick with `frame_strobe` high sets `slot_num` to 0 and makes the written samples live. If the strobe arrives off its 256-slot schedule, the output again follows the map from slot 2 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-clock pulse at each 2.048 MHz slot boundary |
| frame_strobe | input | 1 | Frame mark, taken only together with `slot_tick`; marks slot 0 |
| tone_we | input | 1 | Tone sample write strobe |
| tone_idx | input | 5 | Tone number being written (0..23) |
| tone_sample | input | 8 | New PCM sample for that tone |
| tbl_we | input | 1 | Slot map write strobe from the host |
| tbl_addr | input | 8 | Slot map entry being written |
| tbl_valid | input | 1 | Valid flag of the written entry |
| tbl_tone | input | 5 | Tone index of the written entry |
| slot_num | output | 8 | Bus slot now being driven |
| slot_oe | output | 1 | High when the current slot carries a tone |
| slot_data | output | 8 | Sample for the current slot, 0xFF when idle |

## Verification
A table of map entries is loaded: valid tones at both ends of the index range, indices 24 and 31 with the flag set, a cleared flag, and slots at both ends of the frame. The bench then compares whole frames slot by slot. The first frame, before any strobe, must show zero samples, which separates the live copy from the shadow copy. Later frames separate correct tone indirection from wrong-index and missing-validity decoding. Directed patterns then move a sample mid-frame, which tells a frame-atomic swap from a direct write. They write a map entry in the exact clock of its fetch and a few slots before it, which tells the lookahead timing from an off-by-one counter. Finally, a strobe is dropped and one arrives early, which separates free wrapping from re-alignment.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

   // Slots the fetch counter runs ahead of the bus: one for the map read,
   // one for the tone read into the output register.
   localparam int unsigned TSD_LOOKAHEAD = 2;

   // An entry drives the bus only with its flag set and an existing tone.
   function automatic logic entry_live(input logic valid,
                                       input int unsigned idx,
                                       input int unsigned n_tones);
      return valid && (idx < n_tones);
   endfunction

endpackage

// File: rtl/tsd_slot_timer.sv
module tsd_slot_timer #(
   parameter int unsigned SLOT_W = 8,
   parameter int unsigned LEAD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_tick,
   input  logic              frame_strobe,
   output logic              frame_evt,
   output logic [SLOT_W-1:0] fetch_addr,
   output logic [SLOT_W-1:0] bus_slot
);

   localparam logic [SLOT_W-1:0] LEAD_V = SLOT_W'(LEAD);

   logic [SLOT_W-1:0] cnt_q;

   assign frame_evt = slot_tick & frame_strobe;

   // cnt_q always sits LEAD slots ahead of the slot on the bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LEAD_V;
      end else if (frame_evt) begin
         cnt_q <= LEAD_V;
      end else if (slot_tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fetch_addr = cnt_q;
   assign bus_slot   = cnt_q - LEAD_V;

endmodule

// File: rtl/tsd_slot_table.sv
module tsd_slot_table #(
   parameter int unsigned NUM_SLOTS   = 256,
   parameter int unsigned SLOT_W      = 8,
   parameter int unsigned IDX_W       = 5,
   parameter bit          RESET_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_addr,
   input  logic              wr_valid,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [IDX_W-1:0]  rd_idx
);

   localparam int unsigned ENT_W = IDX_W + 1;

   logic [ENT_W-1:0] mem [NUM_SLOTS];
   logic [ENT_W-1:0] rd_q;

   // Write port: the host side.
   generate
      if (RESET_TABLE) begin : g_clr_map
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(NUM_SLOTS); i++) begin
                  mem[i] <= '0;
               end
            end else if (wr_en) begin
               mem[wr_addr] <= {wr_valid, wr_idx};
            end
         end
      end else begin : g_raw_map
         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[wr_addr] <= {wr_valid, wr_idx};
            end
         end
      end
   endgenerate

   // Read port: the counter side. Same-clock write returns the old entry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= mem[rd_addr];
      end
   end

   assign {rd_valid, rd_idx} = rd_q;

endmodule

// File: rtl/tsd_tone_store.sv
module tsd_tone_store #(
   parameter int unsigned NUM_TONES = 24,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned SAMP_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SAMP_W-1:0] wr_data,
   input  logic              swap,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SAMP_W-1:0] rd_data
);

   logic [SAMP_W-1:0] view [NUM_TONES];

   generate
      for (genvar g = 0; g < int'(NUM_TONES); g++) begin : g_lane
         logic [SAMP_W-1:0] shadow_q;
         logic [SAMP_W-1:0] live_q;
         logic              hit;

         assign hit = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               live_q   <= '0;
            end else begin
               if (hit)  shadow_q <= wr_data;
               if (swap) live_q   <= shadow_q;
            end
         end

         // On the swap clock the first slot of the new frame already sees
         // the value that is being copied into the live lane.
         assign view[g] = swap ? shadow_q : live_q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < int'(NUM_TONES); i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = view[i];
      end
   end

endmodule

// File: rtl/tone_slot_dist.sv
module tone_slot_dist #(
   parameter int unsigned        NUM_SLOTS   = 256,
   parameter int unsigned        NUM_TONES   = 24,
   parameter int unsigned        SAMP_W      = 8,
   parameter int unsigned        IDX_W       = 5,
   parameter logic [SAMP_W-1:0]  IDLE_CODE   = '1,
   parameter bit                 RESET_TABLE = 1'b1,
   localparam int unsigned       SLOT_W      = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_tick,
   input  logic              frame_strobe,
   input  logic              tone_we,
   input  logic [IDX_W-1:0]  tone_idx,
   input  logic [SAMP_W-1:0] tone_sample,
   input  logic              tbl_we,
   input  logic [SLOT_W-1:0] tbl_addr,
   input  logic              tbl_valid,
   input  logic [IDX_W-1:0]  tbl_tone,
   output logic [SLOT_W-1:0] slot_num,
   output logic              slot_oe,
   output logic [SAMP_W-1:0] slot_data
);

   localparam int unsigned LEAD = tsd_pkg::TSD_LOOKAHEAD;

   generate
      if (NUM_SLOTS != (1 << SLOT_W)) begin : g_bad_slots
         $error("NUM_SLOTS must be a power of two");
      end
      if (NUM_TONES < 1 || NUM_TONES > (1 << IDX_W)) begin : g_bad_tones
         $error("NUM_TONES must fit the tone index width");
      end
      if (LEAD >= NUM_SLOTS) begin : g_bad_lead
         $error("lookahead must be shorter than the frame");
      end
   endgenerate

   logic              frame_evt;
   logic [SLOT_W-1:0] fetch_addr;
   logic [SLOT_W-1:0] bus_slot;
   logic              ent_valid;
   logic [IDX_W-1:0]  ent_idx;
   logic [SAMP_W-1:0] tone_q;
   logic              ent_ok;

   tsd_slot_timer #(
      .SLOT_W (SLOT_W),
      .LEAD   (LEAD)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_tick    (slot_tick),
      .frame_strobe (frame_strobe),
      .frame_evt    (frame_evt),
      .fetch_addr   (fetch_addr),
      .bus_slot     (bus_slot)
   );

   tsd_slot_table #(
      .NUM_SLOTS   (NUM_SLOTS),
      .SLOT_W      (SLOT_W),
      .IDX_W       (IDX_W),
      .RESET_TABLE (RESET_TABLE)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_addr  (tbl_addr),
      .wr_valid (tbl_valid),
      .wr_idx   (tbl_tone),
      .rd_en    (slot_tick),
      .rd_addr  (fetch_addr),
      .rd_valid (ent_valid),
      .rd_idx   (ent_idx)
   );

   tsd_tone_store #(
      .NUM_TONES (NUM_TONES),
      .IDX_W     (IDX_W),
      .SAMP_W    (SAMP_W)
   ) u_tones (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tone_we),
      .wr_idx  (tone_idx),
      .wr_data (tone_sample),
      .swap    (frame_evt),
      .rd_idx  (ent_idx),
      .rd_data (tone_q)
   );

   assign ent_ok = tsd_pkg::entry_live(ent_valid, 32'(ent_idx), NUM_TONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_oe   <= 1'b0;
         slot_data <= IDLE_CODE;
      end else if (slot_tick) begin
         slot_oe   <= ent_ok;
         slot_data <= ent_ok ? tone_q : IDLE_CODE;
      end
   end

   assign slot_num = bus_slot;

endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
   parameter int unsigned       SLOT_W    = 8,
   parameter int unsigned       NUM_TONES = 24,
   parameter int unsigned       SAMP_W    = 8,
   parameter int unsigned       IDX_W     = 5,
   parameter logic [SAMP_W-1:0] IDLE_CODE = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slot_tick,
   input logic              frame_strobe,
   input logic [SLOT_W-1:0] slot_num,
   input logic              slot_oe,
   input logic [SAMP_W-1:0] slot_data,
   input logic              ent_valid,
   input logic [IDX_W-1:0]  ent_idx
);

   localparam logic [IDX_W:0] NT = (IDX_W+1)'(NUM_TONES);

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick && !frame_strobe |=> slot_num == SLOT_W'($past(slot_num) + 1'b1));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> $stable(slot_num) && $stable(slot_oe) && $stable(slot_data));

   p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick && frame_strobe |=> slot_num == '0);

   p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_oe |-> slot_data == IDLE_CODE);

   p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick && ent_valid && ({1'b0, ent_idx} < NT) |=> slot_oe);

   p_bad_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick && ent_valid && ({1'b0, ent_idx} >= NT) |=> !slot_oe);

   p_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick && !ent_valid |=> !slot_oe);

endmodule

bind tone_slot_dist tsd_checker #(
   .SLOT_W    (SLOT_W),
   .NUM_TONES (NUM_TONES),
   .SAMP_W    (SAMP_W),
   .IDX_W     (IDX_W),
   .IDLE_CODE (IDLE_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slot_tick    (slot_tick),
   .frame_strobe (frame_strobe),
   .slot_num     (slot_num),
   .slot_oe      (slot_oe),
   .slot_data    (slot_data),
   .ent_valid    (ent_valid),
   .ent_idx      (ent_idx)
);

// File: tb/sim_tone_slot_dist.sv
module sim_tone_slot_dist;

   localparam int CLK_PERIOD = 10;
   localparam int GAP        = 2;
   localparam int NV         = 12;

   // {slot[7:0], valid, tone[4:0], expected oe}
   localparam logic [14:0] VEC [NV] = '{
      {8'd0,   1'b1, 5'd0,  1'b1},
      {8'd2,   1'b1, 5'd23, 1'b1},
      {8'd3,   1'b1, 5'd23, 1'b1},
      {8'd5,   1'b1, 5'd5,  1'b1},
      {8'd10,  1'b1, 5'd5,  1'b1},
      {8'd100, 1'b1, 5'd7,  1'b1},
      {8'd200, 1'b1, 5'd5,  1'b1},
      {8'd201, 1'b1, 5'd24, 1'b0},
      {8'd202, 1'b1, 5'd31, 1'b0},
      {8'd203, 1'b0, 5'd3,  1'b0},
      {8'd254, 1'b1, 5'd12, 1'b1},
      {8'd255, 1'b1, 5'd1,  1'b1}
   };

   logic       clk;
   logic       rst_n;
   logic       slot_tick;
   logic       frame_strobe;
   logic       tone_we;
   logic [4:0] tone_idx;
   logic [7:0] tone_sample;
   logic       tbl_we;
   logic [7:0] tbl_addr;
   logic       tbl_valid;
   logic [4:0] tbl_tone;
   logic [7:0] slot_num;
   logic       slot_oe;
   logic [7:0] slot_data;

   tone_slot_dist u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_tick    (slot_tick),
      .frame_strobe (frame_strobe),
      .tone_we      (tone_we),
      .tone_idx     (tone_idx),
      .tone_sample  (tone_sample),
      .tbl_we       (tbl_we),
      .tbl_addr     (tbl_addr),
      .tbl_valid    (tbl_valid),
      .tbl_tone     (tbl_tone),
      .slot_num     (slot_num),
      .slot_oe      (slot_oe),
      .slot_data    (slot_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk  = 0;
   int    n_fail = 0;
   string phase_tag = "R1";
   int    skip   = 0;
   int    bslot  = 0;

   logic       m_v    [256];
   logic [4:0] m_t    [256];
   logic [7:0] m_shad [24];
   logic [7:0] m_live [24];

   function automatic logic [7:0] smp(input int k, input int gen);
      return 8'(8'h40 + k * 5 + gen * 8'h11);
   endfunction

   task automatic chk_eq(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s slot=%0d %s actual=%0h expected=%0h", tag, bslot, what, act, exp);
      end
   endtask

   task automatic check_slot();
      logic       e_ok;
      logic [7:0] e_d;
      string      tag;
      chk_eq(phase_tag, "slot_num", int'(slot_num), bslot);
      if (skip > 0) begin
         skip--;
      end else begin
         e_ok = m_v[bslot] && (m_t[bslot] < 5'd24);
         e_d  = e_ok ? m_live[m_t[bslot]] : 8'hFF;
         tag  = (m_v[bslot] && m_t[bslot] >= 5'd24) ? "R4" : phase_tag;
         chk_eq(tag, "slot_oe", int'(slot_oe), int'(e_ok));
         chk_eq(tag, "slot_data", int'(slot_data), int'(e_d));
         for (int i = 0; i < NV; i++) begin
            if (int'(VEC[i][14:7]) == bslot && m_v[bslot] == VEC[i][6] && m_t[bslot] == VEC[i][5:1])
               chk_eq((VEC[i][5:1] >= 5'd24) ? "R4" : "R3", "vector oe", int'(slot_oe), int'(VEC[i][0]));
         end
      end
   endtask

   task automatic pulse(input bit fs, input bit we, input int addr, input bit v, input int t);
      @(negedge clk);
      slot_tick    = 1'b1;
      frame_strobe = fs;
      tbl_we       = we;
      tbl_addr     = 8'(addr);
      tbl_valid    = v;
      tbl_tone     = 5'(t);
      @(negedge clk);
      slot_tick    = 1'b0;
      frame_strobe = 1'b0;
      tbl_we       = 1'b0;
      if (fs) begin
         bslot = 0;
         for (int i = 0; i < 24; i++) m_live[i] = m_shad[i];
      end else begin
         bslot = (bslot + 1) % 256;
      end
      check_slot();
      repeat (GAP) @(negedge clk);
   endtask

   task automatic step(input bit fs);
      pulse(fs, 1'b0, 0, 1'b0, 0);
   endtask

   task automatic run_to(input int target);
      while (bslot != target) step(1'b0);
   endtask

   task automatic tone_write(input int k, input logic [7:0] d);
      @(negedge clk);
      tone_we = 1'b1; tone_idx = 5'(k); tone_sample = d;
      @(negedge clk);
      tone_we = 1'b0;
      m_shad[k] = d;
   endtask

   task automatic map_write(input int a, input bit v, input int t);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 8'(a); tbl_valid = v; tbl_tone = 5'(t);
      @(negedge clk);
      tbl_we = 1'b0;
      m_v[a] = v; m_t[a] = 5'(t);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog: run still active actual=timeout expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin m_v[i] = 1'b0; m_t[i] = 5'd0; end
      for (int i = 0; i < 24; i++) begin m_shad[i] = 8'h00; m_live[i] = 8'h00; end
      rst_n = 1'b0; slot_tick = 1'b0; frame_strobe = 1'b0;
      tone_we = 1'b0; tone_idx = '0; tone_sample = '0;
      tbl_we = 1'b0; tbl_addr = '0; tbl_valid = 1'b0; tbl_tone = '0;
      repeat (3) @(negedge clk);

      // R1: reset state
      chk_eq("R1", "slot_num", int'(slot_num), 0);
      chk_eq("R1", "slot_oe", int'(slot_oe), 0);
      chk_eq("R1", "slot_data", int'(slot_data), 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1", "slot_data after release", int'(slot_data), 8'hFF);

      // Load the vector table and the first set of samples.
      for (int i = 0; i < NV; i++) map_write(int'(VEC[i][14:7]), VEC[i][6], int'(VEC[i][5:1]));
      for (int k = 0; k < 24; k++) tone_write(k, smp(k, 0));

      // R6 / R2: no strobe yet, samples still zero, counter wraps freely.
      phase_tag = "R6";
      step(1'b0);
      run_to(255);

      // R3 / R4: first full frame with live samples.
      phase_tag = "R3";
      step(1'b1);
      run_to(255);

      // R6 and R5 inside one frame.
      phase_tag = "R6";
      step(1'b1);
      run_to(50);
      tone_write(5, smp(5, 1));
      run_to(98);
      phase_tag = "R5";
      pulse(1'b0, 1'b1, 100, 1'b1, 9);   // write lands on the fetch of entry 100
      step(1'b0);                         // slot 100 still shows the old entry
      m_v[100] = 1'b1; m_t[100] = 5'd9;
      run_to(120);
      map_write(150, 1'b1, 2);            // ahead of its fetch: seen this frame
      run_to(255);

      // Next frame: new tone 5 sample and new entry 100 visible.
      phase_tag = "R5";
      step(1'b1);
      run_to(100);

      // R2: outputs hold with no tick.
      phase_tag = "R2";
      repeat (12) @(negedge clk);
      check_slot();

      // R7: early strobe re-aligns; slots 0 and 1 are not checked for data.
      phase_tag = "R7";
      tone_write(23, smp(23, 2));
      skip = 2;
      step(1'b1);
      run_to(30);

      // R2: missed strobe, counter wraps without a swap.
      phase_tag = "R2";
      tone_write(0, smp(0, 3));
      run_to(255);
      step(1'b0);
      run_to(5);

      finish_run();
   end

endmodule